// File: doc/BRIEF.md
# Codec Register Command Slot Unit

This block sits on the host side of an AC'97-style link and carries control-register accesses to an attached audio codec. Software first loads a command-data slot register with the value to be written, then writes a command-address slot register. The address-slot write packs a read/write bit and a 7-bit codec register index. That write alone starts the transaction, which goes to the codec over a request/acknowledge port.

On a read, the codec's 16-bit reply lands in a receive data slot register, pre-shifted into slot position. The receive address slot holds an echo of the command word with its read/write bit cleared. A slot flag register reports transmit-empty, receive-busy and receive-valid state for each slot, so software can poll for completion. Bit-serial framing and the codec's own register contents are handled elsewhere.

Top module: `codec_slot_cmd`

## Requirements
- R1: After reset the flag register (select 4) reads 0x07, every slot register reads zero and `codec_req` is low. Flag bits are: 0 slot-1 tx empty, 1 slot-2 tx empty, 2 both-slots tx empty, 3 slot-1 rx busy, 4 slot-2 rx busy, 5 slot-1 rx valid, 6 slot-2 rx valid.
- R2: A host write to select 1 (command-data slot) while idle stores the word, which reads back at select 1. It also clears flag bits 1 and 2.
- R3: A host write to select 0 (command-address slot) while idle does the following:
  - stores the word, which reads back at select 0, and clears flag bits 0 and 2;
  - raises `codec_req` on the next cycle;
  - drives `codec_we` as the inverse of word bit 19, `codec_addr` from word bits 18:12, and `codec_wdata` from bits 19:4 of the stored data slot.
- R4: A read launch (bit 19 = 1) sets flag bits 3 and 4 and clears bits 5 and 6. A write launch leaves bits 3 to 6 unchanged.
- R5: When a read is acknowledged, three things follow:
  - select 2 reads the command-address word with bit 19 cleared;
  - select 3 reads `codec_rdata` shifted left by 4;
  - flag bits 3 and 4 clear and bits 5 and 6 set.
- R6: While `codec_req` is high and `codec_ack` is low, `codec_req`, `codec_we`, `codec_addr` and `codec_wdata` hold their values.
- R7: Flag bits 5 and 6 rise only in the cycle after an acknowledged read.
- R8: In the cycle after `codec_ack` is seen with `codec_req` high, `codec_req` is low and flag bits 0, 1 and 2 are set.
- R9: While `codec_req` is high, host writes to select 0 and select 1 are ignored. No register, flag or codec output changes.
- R10: Selects 5 to 7 read as zero, and host writes to them change no register or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 3 | Register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_sel` (combinational) |
| codec_req | output | 1 | Transaction request to codec |
| codec_we | output | 1 | 1 = write, 0 = read |
| codec_addr | output | 7 | Codec register index |
| codec_wdata | output | 16 | Codec write value |
| codec_ack | input | 1 | Codec completion strobe |
| codec_rdata | input | 16 | Codec read value, valid with `codec_ack` |

## Verification
The bench builds the block with its default parameters: a 32-bit slot word, a 7-bit index, a 16-bit value, the read/write flag at bit 19, the index at bit 12 and the value at bit 4. These put every field boundary inside the words the bench drives. Index values with the top and bottom bits set, data with bits at both ends of the 16-bit field, and stray low bits in the address word show any off-by-one in field extraction or in the read echo. Holding the acknowledge back for several cycles opens the busy window, where both ignored writes and command stability are exercised.

// File: rtl/codec_slot_pkg.sv
package codec_slot_pkg;

    typedef enum logic [2:0] {
        SEL_TX_ADDR = 3'd0,
        SEL_TX_DATA = 3'd1,
        SEL_RX_ADDR = 3'd2,
        SEL_RX_DATA = 3'd3,
        SEL_FLAGS   = 3'd4
    } slot_sel_e;

    // Bit 0 is the least significant field (declared last).
    typedef struct packed {
        logic rx2_valid;
        logic rx1_valid;
        logic rx2_busy;
        logic rx1_busy;
        logic tx_all_empty;
        logic tx2_empty;
        logic tx1_empty;
    } slot_flags_t;

    localparam int FLAG_W = $bits(slot_flags_t);

endpackage

// File: rtl/codec_slot_decode.sv
module codec_slot_decode #(
    parameter int SEL_W = 3
) (
    input  logic             host_wr,
    input  logic [SEL_W-1:0] host_sel,
    output logic             wr_addr_slot,
    output logic             wr_data_slot
);
    import codec_slot_pkg::*;

    always_comb begin
        wr_addr_slot = host_wr && (host_sel == SEL_W'(SEL_TX_ADDR));
        wr_data_slot = host_wr && (host_sel == SEL_W'(SEL_TX_DATA));
    end

endmodule

// File: rtl/codec_slot_rdmux.sv
module codec_slot_rdmux #(
    parameter int SEL_W  = 3,
    parameter int WORD_W = 32
) (
    input  logic [SEL_W-1:0]               sel,
    input  logic [WORD_W-1:0]              tx_addr,
    input  logic [WORD_W-1:0]              tx_data,
    input  logic [WORD_W-1:0]              rx_addr,
    input  logic [WORD_W-1:0]              rx_data,
    input  codec_slot_pkg::slot_flags_t    flags,
    output logic [WORD_W-1:0]              rdata
);
    import codec_slot_pkg::*;

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_W'(SEL_TX_ADDR): rdata = tx_addr;
            SEL_W'(SEL_TX_DATA): rdata = tx_data;
            SEL_W'(SEL_RX_ADDR): rdata = rx_addr;
            SEL_W'(SEL_RX_DATA): rdata = rx_data;
            SEL_W'(SEL_FLAGS):   rdata = WORD_W'(flags);
            default:             rdata = '0;
        endcase
    end

endmodule

// File: rtl/codec_slot_cmd.sv
module codec_slot_cmd #(
    parameter int SEL_W   = 3,
    parameter int WORD_W  = 32,
    parameter int IDX_W   = 7,
    parameter int VAL_W   = 16,
    parameter int RW_BIT  = 19,
    parameter int IDX_LSB = 12,
    parameter int VAL_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [SEL_W-1:0]  host_sel,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              codec_req,
    output logic              codec_we,
    output logic [IDX_W-1:0]  codec_addr,
    output logic [VAL_W-1:0]  codec_wdata,
    input  logic              codec_ack,
    input  logic [VAL_W-1:0]  codec_rdata
);
    import codec_slot_pkg::*;

    localparam logic [WORD_W-1:0] RW_MASK = WORD_W'(1) << RW_BIT;

    typedef struct packed {
        logic [WORD_W-1:0] tx_addr;
        logic [WORD_W-1:0] tx_data;
        logic [WORD_W-1:0] rx_addr;
        logic [WORD_W-1:0] rx_data;
        logic              req;
        logic              we;
        logic [IDX_W-1:0]  idx;
        logic [VAL_W-1:0]  wval;
        slot_flags_t       flags;
    } state_t;

    state_t s_d, s_q;
    logic   wr_addr_slot, wr_data_slot, launch;
    logic [FLAG_W-1:0] flag_vec;

    codec_slot_decode #(.SEL_W(SEL_W)) u_decode (
        .host_wr      (host_wr),
        .host_sel     (host_sel),
        .wr_addr_slot (wr_addr_slot),
        .wr_data_slot (wr_data_slot)
    );

    always_comb begin
        s_d    = s_q;
        launch = wr_addr_slot && !s_q.req;

        if (wr_data_slot && !s_q.req) begin
            s_d.tx_data            = host_wdata;
            s_d.flags.tx2_empty    = 1'b0;
            s_d.flags.tx_all_empty = 1'b0;
        end

        if (launch) begin
            s_d.tx_addr            = host_wdata;
            s_d.flags.tx1_empty    = 1'b0;
            s_d.flags.tx_all_empty = 1'b0;
            s_d.req                = 1'b1;
            s_d.we                 = !host_wdata[RW_BIT];
            s_d.idx                = host_wdata[IDX_LSB +: IDX_W];
            s_d.wval               = s_q.tx_data[VAL_LSB +: VAL_W];
            if (host_wdata[RW_BIT]) begin
                s_d.flags.rx1_busy  = 1'b1;
                s_d.flags.rx2_busy  = 1'b1;
                s_d.flags.rx1_valid = 1'b0;
                s_d.flags.rx2_valid = 1'b0;
            end
        end

        if (s_q.req && codec_ack) begin
            s_d.req                = 1'b0;
            s_d.flags.tx1_empty    = 1'b1;
            s_d.flags.tx2_empty    = 1'b1;
            s_d.flags.tx_all_empty = 1'b1;
            if (!s_q.we) begin
                s_d.rx_addr                  = s_q.tx_addr & ~RW_MASK;
                s_d.rx_data                  = '0;
                s_d.rx_data[VAL_LSB +: VAL_W] = codec_rdata;
                s_d.flags.rx1_busy           = 1'b0;
                s_d.flags.rx2_busy           = 1'b0;
                s_d.flags.rx1_valid          = 1'b1;
                s_d.flags.rx2_valid          = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q                    <= '0;
            s_q.flags.tx1_empty    <= 1'b1;
            s_q.flags.tx2_empty    <= 1'b1;
            s_q.flags.tx_all_empty <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    codec_slot_rdmux #(.SEL_W(SEL_W), .WORD_W(WORD_W)) u_rdmux (
        .sel     (host_sel),
        .tx_addr (s_q.tx_addr),
        .tx_data (s_q.tx_data),
        .rx_addr (s_q.rx_addr),
        .rx_data (s_q.rx_data),
        .flags   (s_q.flags),
        .rdata   (host_rdata)
    );

    assign codec_req   = s_q.req;
    assign codec_we    = s_q.we;
    assign codec_addr  = s_q.idx;
    assign codec_wdata = s_q.wval;
    assign flag_vec    = s_q.flags;

endmodule

// File: rtl/codec_slot_cmd_chk.sv
module codec_slot_cmd_chk #(
    parameter int SEL_W = 3,
    parameter int IDX_W = 7,
    parameter int VAL_W = 16,
    parameter int FLAG_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [SEL_W-1:0]  host_sel,
    input logic              codec_req,
    input logic              codec_we,
    input logic [IDX_W-1:0]  codec_addr,
    input logic [VAL_W-1:0]  codec_wdata,
    input logic              codec_ack,
    input logic [FLAG_W-1:0] flag_vec
);

    assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (codec_req && !codec_ack) |=> codec_req);

    assert_cmd_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (codec_req && !codec_ack) |=>
            ($stable(codec_addr) && $stable(codec_we) && $stable(codec_wdata)));

    assert_launch_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(codec_req) |-> $past(host_wr && (host_sel == '0)));

    assert_valid_on_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_vec[5]) |-> $past(codec_ack && codec_req && !codec_we));

    assert_req_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (codec_req && codec_ack) |=> (!codec_req && (flag_vec[2:0] == 3'b111)));

endmodule

bind codec_slot_cmd codec_slot_cmd_chk #(
    .SEL_W(SEL_W), .IDX_W(IDX_W), .VAL_W(VAL_W), .FLAG_W(codec_slot_pkg::FLAG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_sel    (host_sel),
    .codec_req   (codec_req),
    .codec_we    (codec_we),
    .codec_addr  (codec_addr),
    .codec_wdata (codec_wdata),
    .codec_ack   (codec_ack),
    .flag_vec    (flag_vec)
);

// File: tb/codec_slot_cmd_tb_top.sv
module codec_slot_cmd_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_sel = 3'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        codec_req, codec_we;
    logic [6:0]  codec_addr;
    logic [15:0] codec_wdata;
    logic        codec_ack = 1'b0;
    logic [15:0] codec_rdata = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    codec_slot_cmd dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .codec_req(codec_req), .codec_we(codec_we), .codec_addr(codec_addr),
        .codec_wdata(codec_wdata), .codec_ack(codec_ack), .codec_rdata(codec_rdata)
    );

    typedef struct packed {
        logic [31:0] dword;
        logic [31:0] aword;
        logic [15:0] reply;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{dword: 32'h000A_BCD0, aword: 32'h0002_5003, reply: 16'h0000},
        '{dword: 32'h0000_0000, aword: 32'hFFFF_FFFF, reply: 16'h8001},
        '{dword: 32'hFFF8_0000, aword: 32'h0000_1000, reply: 16'h1234},
        '{dword: 32'h0001_0010, aword: 32'h000B_F00C, reply: 16'hFFFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic peek(input logic [2:0] sel, output logic [31:0] v);
        host_sel = sel;
        #1;
        v = host_rdata;
    endtask

    task automatic ack(input logic [15:0] r);
        @(negedge clk);
        codec_ack = 1'b1; codec_rdata = r;
        @(negedge clk);
        codec_ack = 1'b0; codec_rdata = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [6:0]  valid_bits;
        logic [31:0] last_rx_addr, last_rx_data;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        peek(3'd4, v); check("R1 flags", v, 32'h07);
        for (int s = 0; s < 4; s++) begin
            peek(3'(s), v); check("R1 slot zero", v, 32'h0);
        end
        check("R1 req", {31'b0, codec_req}, 32'h0);

        valid_bits   = 7'h00;
        last_rx_addr = '0;
        last_rx_data = '0;

        for (int i = 0; i < 4; i++) begin
            logic rd;
            rd = VECS[i].aword[19];
            hwrite(3'd1, VECS[i].dword);
            peek(3'd1, v); check("R2 data slot", v, VECS[i].dword);
            peek(3'd4, v); check("R2 flags", v, {25'b0, valid_bits | 7'h01});
            hwrite(3'd0, VECS[i].aword);
            peek(3'd0, v); check("R3 addr slot", v, VECS[i].aword);
            check("R3 req", {31'b0, codec_req}, 32'h1);
            check("R3 we", {31'b0, codec_we}, {31'b0, !rd});
            check("R3 idx", {25'b0, codec_addr}, {25'b0, VECS[i].aword[18:12]});
            check("R3 wdata", {16'b0, codec_wdata}, {16'b0, VECS[i].dword[19:4]});
            if (rd) valid_bits = 7'h00;
            peek(3'd4, v);
            check("R4 flags busy", v, {25'b0, valid_bits | (rd ? 7'h18 : 7'h00)});
            repeat (3) @(negedge clk);
            check("R6 req held", {31'b0, codec_req}, 32'h1);
            check("R6 idx held", {25'b0, codec_addr}, {25'b0, VECS[i].aword[18:12]});
            ack(VECS[i].reply);
            check("R8 req drop", {31'b0, codec_req}, 32'h0);
            if (rd) begin
                valid_bits   = 7'h60;
                last_rx_addr = VECS[i].aword & ~32'h0008_0000;
                last_rx_data = {12'b0, VECS[i].reply, 4'b0};
            end
            peek(3'd4, v); check("R8 R5 flags done", v, {25'b0, valid_bits | 7'h07});
            peek(3'd2, v); check("R5 rx addr", v, last_rx_addr);
            peek(3'd3, v); check("R5 rx data", v, last_rx_data);
        end

        // R9: writes ignored while busy
        hwrite(3'd1, 32'h0000_5550);
        hwrite(3'd0, 32'h0008_3000);
        hwrite(3'd0, 32'h0000_7000);
        check("R9 idx unchanged", {25'b0, codec_addr}, 32'h03);
        check("R9 we unchanged", {31'b0, codec_we}, 32'h0);
        peek(3'd0, v); check("R9 addr slot unchanged", v, 32'h0008_3000);
        hwrite(3'd1, 32'h0000_AAA0);
        peek(3'd1, v); check("R9 data slot unchanged", v, 32'h0000_5550);
        check("R9 wdata unchanged", {16'b0, codec_wdata}, 32'h0555);
        peek(3'd4, v); check("R9 flags", v, 32'h18);
        // R7: no valid before ack
        repeat (2) @(negedge clk);
        peek(3'd4, v); check("R7 valid low before ack", v, 32'h18);
        ack(16'h0F0F);
        peek(3'd4, v); check("R7 valid after ack", v, 32'h67);
        peek(3'd3, v); check("R5 rx data 2", v, 32'h0000_F0F0);

        // R10: unused selects
        hwrite(3'd5, 32'hFFFF_FFFF);
        hwrite(3'd7, 32'hFFFF_FFFF);
        check("R10 no launch", {31'b0, codec_req}, 32'h0);
        for (int s = 5; s < 8; s++) begin
            peek(3'(s), v); check("R10 reads zero", v, 32'h0);
        end
        peek(3'd4, v); check("R10 flags", v, 32'h67);
        peek(3'd1, v); check("R10 data slot", v, 32'h0000_5550);

        // R1: reset again after activity
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        peek(3'd4, v); check("R1 flags after reset", v, 32'h07);
        peek(3'd2, v); check("R1 rx addr after reset", v, 32'h0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule